// File: doc/BRIEF.md
# Dual-Role SPI Byte Controller

This block is a byte-wide SPI port that software configures over a small synchronous register bus. One control bit selects the role. As master, it divides the system clock to make SCK. It raises one of two active-high select outputs and exchanges eight bits with the chosen slave. As slave, it follows an external SCK and select line, both resynchronised into the system clock. In either role it shifts MSB first, and all four clock polarity/phase combinations are available.

A transfer is always full duplex. The byte in the shift register leaves on the outgoing data line while the partner's byte arrives, so the two shift registers trade contents. Completion raises a done flag and latches the received byte into the readable data register. Software polls the flag, and reading the status register clears it. The rate generator counts only while a master transfer is running, and stays idle in slave mode.

Top module: `spi_dual_ctrl`

## Requirements
- R1: After reset every register reads zero, `ss_o` is 0, `sck_o` is 0 and `miso_oe` is 0.
- R2: With control bits en (bit 0) and master (bit 1) set, a write to the data register (address 3) while idle starts a transfer. In the same cycle as busy, it raises exactly one select output: `ss_o[0]` when control bit 4 (target) is 0, `ss_o[1]` when it is 1.
- R3: In master mode, with rate field N (address 2, bits 2:0), SCK toggles every 2^min(N,6) system clocks. Each transfer has exactly 16 toggles, and SCK rests at the polarity bit (control bit 2) whenever no slave is selected.
- R4: In every mode (polarity bit 2, phase bit 3), a master and a slave exchange bytes MSB first. Afterwards each side's data register read returns the other side's byte.
- R5: With phase 0, the master's outgoing line carries bit 7 of the byte from the cycle after the start write, before the first SCK edge.
- R6: The status register (address 1) reports busy in bit 0 and done in bit 1. Done sets in the cycle busy falls, and a read of the status register clears it.
- R7: A data-register write made while a master transfer is busy has no effect on the byte sent.
- R8: In slave mode the block drives no select output and holds `sck_o` at the polarity bit.
- R9: `miso_oe` is high only in enabled slave mode while `ss_i` is high. It is always low in master mode.
- R10: With en clear, a data-register write starts nothing: busy stays 0 and no select output rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears done on status reads) |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 rate, 3 data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from address |
| sck_o | output | 1 | Serial clock generated in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| mosi_o | output | 1 | Master-out data in master mode |
| mosi_i | input | 1 | Master-out data received in slave mode |
| miso_o | output | 1 | Slave-out data in slave mode |
| miso_oe | output | 1 | Output enable for `miso_o` (tri-state control) |
| miso_i | input | 1 | Slave-out data received in master mode |
| ss_o | output | 2 | Active-high select outputs for two slaves |
| ss_i | input | 1 | Active-high select input in slave mode |

## Verification
A wrong edge count or a wrong leading/trailing decision shows within a single transfer. The received byte comes back rotated or with a bit dropped, and the SCK output shows a toggle count other than 16. A stuck rate stage shows at the ports as a half-period that differs from 2^N on the very first SCK edge. A done or busy flag left in the wrong state shows on the next status read. A select line left raised shows as a non-idle SCK or a selected slave once the transfer is over.

// File: rtl/spi_dual_pkg.sv
package spi_dual_pkg;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned EDGES    = 2 * BYTE_W;
    localparam int unsigned CNT_W    = $clog2(EDGES + 2);
    localparam int unsigned RATE_W   = 3;
    localparam int unsigned RATE_MAX = 6;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_RATE = 2'd2;
    localparam logic [1:0] A_DATA = 2'd3;

    typedef struct packed {
        logic target;
        logic cpha;
        logic cpol;
        logic master;
        logic en;
    } cfg_t;

    typedef struct packed {
        cfg_t              cfg;
        logic [RATE_W-1:0] rate;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] rxd;
        logic              smp;
        logic              outb;
        logic [CNT_W-1:0]  ecnt;
        logic              busy;
        logic              done;
        logic              sck;
        logic [1:0]        ss;
        logic              ss_prev;
        logic              sck_prev;
    } core_t;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
    parameter int unsigned RATE_W   = 3,
    parameter int unsigned RATE_MAX = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int unsigned STG_W = (RATE_MAX > 0) ? RATE_MAX : 1;

    logic [STG_W-1:0]  cnt_d, cnt_q;
    logic [STG_W-1:0]  stage_used;
    logic [RATE_W-1:0] eff;

    assign eff = (32'(rate) > RATE_MAX) ? RATE_W'(RATE_MAX) : rate;

    // each divider stage halves the rate; a stage joins the tap when selected
    for (genvar i = 0; i < STG_W; i++) begin : g_stage
        assign stage_used[i] = (32'(eff) > i);
    end

    assign tick = &(cnt_q | ~stage_used);

    always_comb begin
        cnt_d = run ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/spi_dual_ctrl.sv
module spi_dual_ctrl
    import spi_dual_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              sck_o,
    input  logic              sck_i,
    output logic              mosi_o,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              miso_i,
    output logic [1:0]        ss_o,
    input  logic              ss_i
);
    core_t q, n;

    logic              tick;
    logic              s_sck, s_mosi, s_ss;
    logic              wr_data;
    logic              lead;
    logic [BYTE_W-1:0] nxt_sh;

    // observation points for the checker
    logic cfg_en, cfg_master, cfg_cpol, busy_w, done_w;
    assign cfg_en     = q.cfg.en;
    assign cfg_master = q.cfg.master;
    assign cfg_cpol   = q.cfg.cpol;
    assign busy_w     = q.busy;
    assign done_w     = q.done;

    spi_rate_gen #(
        .RATE_W  (RATE_W),
        .RATE_MAX(RATE_MAX)
    ) u_rate (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (q.busy && q.cfg.en && q.cfg.master),
        .rate (q.rate),
        .tick (tick)
    );

    spi_pin_sync #(
        .W     (3),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({sck_i, mosi_i, ss_i}),
        .sync_out({s_sck, s_mosi, s_ss})
    );

    assign wr_data = reg_wr && (reg_addr == A_DATA);

    always_comb begin
        n      = q;
        lead   = 1'b0;
        nxt_sh = q.shreg;

        if (reg_wr && reg_addr == A_CTRL) n.cfg  = cfg_t'(reg_wdata[4:0]);
        if (reg_wr && reg_addr == A_RATE) n.rate = reg_wdata[RATE_W-1:0];
        if (reg_rd && reg_addr == A_STAT) n.done = 1'b0;

        n.ss_prev  = s_ss;
        n.sck_prev = s_sck;

        if (q.cfg.en && q.cfg.master) begin
            if (!q.busy) begin
                n.sck = n.cfg.cpol;
                if (wr_data) begin
                    n.shreg = reg_wdata;
                    n.outb  = reg_wdata[BYTE_W-1];
                    n.busy  = 1'b1;
                    n.ecnt  = '0;
                    n.ss    = q.cfg.target ? 2'b10 : 2'b01;
                end
            end else if (tick) begin
                if (q.ecnt == CNT_W'(EDGES)) begin
                    // guard half-period elapsed after the last edge
                    n.busy = 1'b0;
                    n.done = 1'b1;
                    n.rxd  = q.shreg;
                    n.ss   = 2'b00;
                    n.sck  = q.cfg.cpol;
                end else begin
                    n.sck  = ~q.sck;
                    n.ecnt = q.ecnt + 1'b1;
                    lead   = ~q.ecnt[0];
                    if (lead) begin
                        if (q.cfg.cpha) n.outb = q.shreg[BYTE_W-1];
                        else            n.smp  = miso_i;
                    end else begin
                        n.shreg = {q.shreg[BYTE_W-2:0], q.cfg.cpha ? miso_i : q.smp};
                    end
                end
            end
        end else begin
            n.ss  = 2'b00;
            n.sck = n.cfg.cpol;
            if (q.cfg.en) begin
                if (!q.busy && wr_data) begin
                    n.shreg = reg_wdata;
                    n.outb  = reg_wdata[BYTE_W-1];
                end
                if (s_ss && !q.ss_prev) begin
                    n.busy = 1'b1;
                    n.ecnt = '0;
                    n.outb = n.shreg[BYTE_W-1];
                end else if (!s_ss) begin
                    n.busy = 1'b0;
                end else if (q.busy && (s_sck != q.sck_prev)) begin
                    lead   = (s_sck != q.cfg.cpol);
                    n.ecnt = q.ecnt + 1'b1;
                    if (lead) begin
                        if (q.cfg.cpha) n.outb = q.shreg[BYTE_W-1];
                        else            n.smp  = s_mosi;
                    end else begin
                        nxt_sh  = {q.shreg[BYTE_W-2:0], q.cfg.cpha ? s_mosi : q.smp};
                        n.shreg = nxt_sh;
                    end
                    if (q.ecnt == CNT_W'(EDGES - 1)) begin
                        n.busy = 1'b0;
                        n.done = 1'b1;
                        n.rxd  = nxt_sh;
                    end
                end
            end else begin
                n.busy = 1'b0;
                n.ecnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = BYTE_W'(q.cfg);
            A_STAT:  reg_rdata = BYTE_W'({q.done, q.busy});
            A_RATE:  reg_rdata = BYTE_W'(q.rate);
            default: reg_rdata = q.rxd;
        endcase
    end

    assign sck_o   = q.sck;
    assign ss_o    = q.ss;
    assign mosi_o  = q.cfg.cpha ? q.outb : q.shreg[BYTE_W-1];
    assign miso_o  = q.cfg.cpha ? q.outb : q.shreg[BYTE_W-1];
    assign miso_oe = q.cfg.en && !q.cfg.master && ss_i;
endmodule

// File: rtl/spi_dual_chk.sv
module spi_dual_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_master,
    input logic       cfg_cpol,
    input logic       busy,
    input logic       done,
    input logic [1:0] ss_o,
    input logic       sck_o,
    input logic       miso_oe,
    input logic       ss_i
);
    // R2
    ss_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ss_o));

    // R2
    ss_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && cfg_master) |-> ($countones(ss_o) == 1));

    // R3
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_o == 2'b00 && $past(ss_o) == 2'b00) |-> (sck_o == cfg_cpol));

    // R6
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy));

    // R8
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_master && $past(!cfg_master)) |-> (ss_o == 2'b00));

    // R9
    miso_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_i |-> !miso_oe);
endmodule

bind spi_dual_ctrl spi_dual_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_master(cfg_master),
    .cfg_cpol  (cfg_cpol),
    .busy      (busy_w),
    .done      (done_w),
    .ss_o      (ss_o),
    .sck_o     (sck_o),
    .miso_oe   (miso_oe),
    .ss_i      (ss_i)
);

// File: tb/spi_dual_ctrl_test.sv
module spi_dual_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // master side (uut)
    logic       m_wr = 0, m_rd = 0;
    logic [1:0] m_addr = 0;
    logic [7:0] m_wdata = 0, m_rdata;
    logic       m_sck, m_mosi, m_miso_o, m_miso_oe;
    logic [1:0] m_ss;
    // slave side (peer)
    logic       p_wr = 0, p_rd = 0;
    logic [1:0] p_addr = 0;
    logic [7:0] p_wdata = 0, p_rdata;
    logic       p_sck, p_mosi, p_miso_o, p_miso_oe;
    logic [1:0] p_ss;

    logic psel = 0, ss_ovr = 0, ss_ovr_val = 0;
    logic peer_ss, m_miso_in;
    assign peer_ss   = ss_ovr ? ss_ovr_val : m_ss[psel];
    assign m_miso_in = p_miso_oe ? p_miso_o : 1'b0;

    spi_dual_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(m_wr), .reg_rd(m_rd), .reg_addr(m_addr), .reg_wdata(m_wdata), .reg_rdata(m_rdata),
        .sck_o(m_sck), .sck_i(1'b0), .mosi_o(m_mosi), .mosi_i(1'b0),
        .miso_o(m_miso_o), .miso_oe(m_miso_oe), .miso_i(m_miso_in),
        .ss_o(m_ss), .ss_i(1'b0)
    );

    spi_dual_ctrl peer (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(p_wr), .reg_rd(p_rd), .reg_addr(p_addr), .reg_wdata(p_wdata), .reg_rdata(p_rdata),
        .sck_o(p_sck), .sck_i(m_sck), .mosi_o(p_mosi), .mosi_i(m_mosi),
        .miso_o(p_miso_o), .miso_oe(p_miso_oe), .miso_i(1'b0),
        .ss_o(p_ss), .ss_i(peer_ss)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input bit to_peer, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        if (to_peer) begin p_wr = 1; p_addr = a; p_wdata = d; end
        else         begin m_wr = 1; m_addr = a; m_wdata = d; end
        @(negedge clk);
        p_wr = 0; m_wr = 0;
    endtask

    task automatic bus_rd(input bit to_peer, input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        if (to_peer) begin p_rd = 1; p_addr = a; end
        else         begin m_rd = 1; m_addr = a; end
        #1 d = to_peer ? p_rdata : m_rdata;
        @(negedge clk);
        p_rd = 0; m_rd = 0;
    endtask

    function automatic int half_of(input int nsel);
        return 1 << ((nsel > 6) ? 6 : nsel);
    endfunction

    // R3: SCK timing sweep for one rate and polarity
    task automatic period_test(input int nsel, input logic cpol);
        logic [7:0] rd;
        int half, toggles, last, bad;
        logic prev;
        half = half_of(nsel);
        bus_wr(1, 2'd0, 8'h00);
        bus_wr(0, 2'd2, 8'(nsel));
        bus_wr(0, 2'd0, {3'b0, 1'b0, 1'b0, cpol, 1'b1, 1'b1});
        chk(m_sck == cpol, "R3 idle level", m_sck, cpol);
        bus_wr(0, 2'd3, 8'h81);
        toggles = 0; last = -1; bad = 0; prev = m_sck;
        for (int c = 0; c < 17 * half + 20; c++) begin
            @(negedge clk);
            if (m_sck != prev) begin
                if (last >= 0 && (c - last) != half) bad++;
                last = c;
                toggles++;
                prev = m_sck;
            end
        end
        chk(toggles == 16, "R3 toggle count", toggles, 16);
        chk(bad == 0, "R3 half period", bad, 0);
        chk(m_sck == cpol && m_ss == 2'b00, "R3 rest level", m_sck, cpol);
        bus_rd(0, 2'd1, rd);
        chk(rd == 8'h02, "R6 done after transfer", rd, 8'h02);
    endtask

    // R4: exchange between master and slave
    task automatic xfer(input int nsel, input logic cpol, input logic cpha, input logic sel,
                        input logic [7:0] m, input logic [7:0] s, input bit poke);
        logic [7:0] rd;
        int half;
        half = half_of(nsel);
        psel = sel;
        bus_wr(0, 2'd2, 8'(nsel));
        bus_wr(0, 2'd0, {3'b0, sel, cpha, cpol, 1'b1, 1'b1});
        bus_wr(1, 2'd0, {3'b0, 1'b0, cpha, cpol, 1'b0, 1'b1});
        bus_wr(1, 2'd3, s);
        repeat (4) @(negedge clk);
        bus_wr(0, 2'd3, m);
        chk(m_ss == (sel ? 2'b10 : 2'b01), "R2 select raised", m_ss, sel ? 2 : 1);
        if (!cpha) chk(m_mosi == m[7], "R5 first bit early", m_mosi, m[7]);
        if (poke) begin
            repeat (20) @(negedge clk);
            bus_wr(0, 2'd3, ~m);
        end
        repeat (17 * half + 20) @(negedge clk);
        bus_rd(0, 2'd1, rd);
        chk(rd == 8'h02, "R6 master done", rd, 8'h02);
        bus_rd(0, 2'd1, rd);
        chk(rd == 8'h00, "R6 done cleared by read", rd, 8'h00);
        bus_rd(0, 2'd3, rd);
        chk(rd == s, "R4 master received", rd, s);
        bus_rd(1, 2'd1, rd);
        chk(rd[1] == 1'b1, "R6 slave done", rd, 8'h02);
        bus_rd(1, 2'd3, rd);
        chk(rd == m, poke ? "R7 busy write ignored" : "R4 slave received", rd, m);
        chk(p_sck == cpol && p_ss == 2'b00, "R8 slave drives no clock or select", {p_ss, p_sck}, cpol);
    endtask

    initial begin
        logic [7:0] rd;
        logic [7:0] mv, sv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        chk(m_ss == 0 && m_sck == 0 && m_miso_oe == 0 && p_miso_oe == 0, "R1 reset pins",
            {m_ss, m_sck, m_miso_oe}, 0);
        for (int a = 0; a < 4; a++) begin
            bus_rd(0, 2'(a), rd);
            chk(rd == 0, "R1 reset register", rd, 0);
        end

        // R10: disabled master ignores data writes
        bus_wr(0, 2'd0, 8'h02);
        bus_wr(0, 2'd3, 8'h77);
        repeat (30) begin
            @(negedge clk);
            if (m_ss != 0) break;
        end
        chk(m_ss == 2'b00, "R10 no select when disabled", m_ss, 0);
        bus_rd(0, 2'd1, rd);
        chk(rd == 8'h00, "R10 not busy when disabled", rd, 0);

        // R3 sweep over every rate code and both polarities
        for (int nsel = 0; nsel < 8; nsel++)
            for (int p = 0; p < 2; p++)
                period_test(nsel, p[0]);

        // R4/R5/R6 sweep over modes, rates and byte patterns
        for (int md = 0; md < 4; md++)
            for (int nsel = 3; nsel < 5; nsel++)
                for (int k = 0; k < 6; k++) begin
                    mv = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(k * 37 + md * 11 + 5);
                    sv = (k == 0) ? 8'hFF : (k == 1) ? 8'h00 : 8'(~(k * 53) ^ (md * 29));
                    xfer(nsel, md[1], md[0], 1'b0, mv, sv, 1'b0);
                end

        // R2 second select output
        xfer(3, 1'b0, 1'b1, 1'b1, 8'hC3, 8'h5E, 1'b0);
        xfer(3, 1'b1, 1'b0, 1'b1, 8'h19, 8'hE4, 1'b0);
        // R7 data write during a busy transfer
        xfer(4, 1'b0, 1'b0, 1'b0, 8'h5A, 8'h96, 1'b1);
        xfer(3, 1'b1, 1'b1, 1'b0, 8'h0F, 8'hF0, 1'b1);

        // R9 output enable follows slave select
        bus_wr(1, 2'd0, 8'h01);
        ss_ovr = 1; ss_ovr_val = 0;
        @(negedge clk);
        chk(p_miso_oe == 0, "R9 tri-state when deselected", p_miso_oe, 0);
        ss_ovr_val = 1;
        #1;
        chk(p_miso_oe == 1, "R9 driven when selected", p_miso_oe, 1);
        chk(m_miso_oe == 0, "R9 master never drives", m_miso_oe, 0);
        @(negedge clk);
        ss_ovr_val = 0;
        #1;
        chk(p_miso_oe == 0, "R9 released on deselect", p_miso_oe, 0);
        ss_ovr = 0;

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule